// File: doc/BRIEF.md
# Link Alignment Character Monitor

This block sits in the receive path of a serial converter lane. It comes after the 8b/10b decoder and before the descrambler. Each decoded octet arrives with its control-character flag. The block tracks the octet's position inside the current frame and multiframe and picks out the two alignment control characters. The frame character is a control octet of 0xFC. The multiframe character is a control octet of 0x7C.

When an alignment character lands on a boundary where it is allowed, the block turns it back into the data octet it replaced and clears its control flag. With scrambling on, that data octet is the fixed value the transmitter substituted. With scrambling off, it is the last octet of the previous frame. When an alignment character lands anywhere else, the block passes it through untouched, raises a one-cycle realignment request and increments a saturating error counter.

Lane alignment logic drives a start-of-multiframe strobe that restarts the position count. Frame length and multiframe length are run-time settings, each given as a count minus one.

Top module: `lane_align_mon`

## Requirements
- R1: A valid octet with the control flag set and value 0xFC (frame character) is accepted when it is the last octet of a frame, including the last frame of a multiframe. A control octet of 0x7C (multiframe character) is accepted only when it is the last octet of a multiframe.
- R2: An accepted alignment character leaves the block with out_is_k cleared.
- R3: With cfg_scram_en high, an accepted frame character is output as 0xFC and an accepted multiframe character as 0x7C.
- R4: With cfg_scram_en low, an accepted character is output as the octet that was output at the last position of the previous frame. Restored octets count as output octets. The value is 0x00 after reset.
- R5: A frame or multiframe character that is not accepted is forwarded with its value and control flag unchanged. realign_req is high for exactly the one output cycle that carries it.
- R6: A frame holds cfg_frame_len_m1+1 octets and a multiframe holds cfg_mf_len_m1+1 frames. Only cycles with in_valid high advance the position. A valid octet with in_mf_start high is the first octet of a multiframe.
- R7: err_count increments by one for each misplaced character and stops at 255. It clears to 0 on the cycle after err_clr is high. Clear takes priority over a same-cycle increment.
- R8: Every valid octet appears on the outputs exactly one clock later, and out_valid follows in_valid with one clock of delay. Octets that are not alignment characters, including other control characters, pass through unchanged.
- R9: A synchronous, active-high rst clears out_valid, out_data, out_is_k, realign_req, err_count, the stored previous octet and the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_scram_en | input | 1 | Scrambling active on the link |
| cfg_frame_len_m1 | input | 8 | Octets per frame minus one |
| cfg_mf_len_m1 | input | 5 | Frames per multiframe minus one |
| in_valid | input | 1 | Input octet present |
| in_data | input | 8 | Decoded octet |
| in_is_k | input | 1 | Octet is a control character |
| in_mf_start | input | 1 | Current octet opens a multiframe |
| err_clr | input | 1 | Synchronous clear of the error counter |
| out_valid | output | 1 | Output octet present |
| out_data | output | 8 | Restored octet |
| out_is_k | output | 1 | Control flag of the output octet |
| realign_req | output | 1 | One-cycle request for link realignment |
| err_count | output | 8 | Saturating count of misplaced characters |

## Verification
Two functions can act in the same cycle: a misplaced character that would increment the error counter, and a software clear of that counter. The bench drives err_clr on the same octet as a misplaced frame character, both while the counter is saturated and after a long run of errors. It expects a count of zero, with the realignment pulse still present. A second overlap is a start-of-multiframe strobe on an octet that is also an alignment character. Here the behavioural model judges acceptance against the restarted position rather than the old one.

// File: rtl/lam_pkg.sv
package lam_pkg;

    localparam int OCT_W = 8;
    localparam logic [OCT_W-1:0] FRAME_CHR  = 8'hFC;
    localparam logic [OCT_W-1:0] MFRAME_CHR = 8'h7C;

    typedef struct packed {
        logic [OCT_W-1:0] data;
        logic             is_k;
    } octet_t;

    typedef enum logic [1:0] {
        CH_PLAIN  = 2'd0,
        CH_FRAME  = 2'd1,
        CH_MFRAME = 2'd2
    } chr_e;

    function automatic chr_e classify(octet_t o);
        if (!o.is_k)                 return CH_PLAIN;
        else if (o.data == FRAME_CHR)  return CH_FRAME;
        else if (o.data == MFRAME_CHR) return CH_MFRAME;
        else                         return CH_PLAIN;
    endfunction

endpackage

// File: rtl/lam_pos_ctr.sv
module lam_pos_ctr #(
    parameter int FL_W = 8,
    parameter int MF_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            mf_start,
    input  logic [FL_W-1:0] cfg_fl_m1,
    input  logic [MF_W-1:0] cfg_mf_m1,
    output logic            frame_end,
    output logic            mframe_end
);
    logic [FL_W-1:0] oct_q, oct_cur;
    logic [MF_W-1:0] frm_q, frm_cur;

    // Position of the octet now at the input; a multiframe strobe restarts it.
    assign oct_cur    = mf_start ? '0 : oct_q;
    assign frm_cur    = mf_start ? '0 : frm_q;
    assign frame_end  = (oct_cur >= cfg_fl_m1);
    assign mframe_end = frame_end && (frm_cur >= cfg_mf_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            oct_q <= '0;
            frm_q <= '0;
        end else if (adv) begin
            if (frame_end) begin
                oct_q <= '0;
                frm_q <= mframe_end ? '0 : frm_cur + 1'b1;
            end else begin
                oct_q <= oct_cur + 1'b1;
                frm_q <= frm_cur;
            end
        end
    end

    // R6
    mf_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && mf_start && cfg_fl_m1 != '0) |=> (oct_q == FL_W'(1) && frm_q == '0));

endmodule

// File: rtl/lam_restore.sv
module lam_restore
    import lam_pkg::*;
(
    input  octet_t            oct_in,
    input  logic              frame_end,
    input  logic              mframe_end,
    input  logic              scram_en,
    input  logic [OCT_W-1:0]  prev_last,
    output octet_t            oct_out,
    output logic              misplaced
);
    chr_e kind;
    logic accepted;

    always_comb begin
        kind      = classify(oct_in);
        accepted  = ((kind == CH_FRAME)  && frame_end) ||
                    ((kind == CH_MFRAME) && mframe_end);
        misplaced = (kind != CH_PLAIN) && !accepted;
        oct_out   = oct_in;
        if (accepted) begin
            oct_out.is_k = 1'b0;
            if (scram_en)
                oct_out.data = (kind == CH_FRAME) ? FRAME_CHR : MFRAME_CHR;
            else
                oct_out.data = prev_last;
        end
    end

endmodule

// File: rtl/lam_err_ctr.sv
module lam_err_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX_CNT = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc && count != MAX_CNT)
            count <= count + 1'b1;
    end

    // R7
    no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr)) |-> (count >= $past(count)));

    // R7
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr) && $past(count) == MAX_CNT) |-> (count == MAX_CNT));

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (count == '0));

endmodule

// File: rtl/lane_align_mon.sv
module lane_align_mon
    import lam_pkg::*;
#(
    parameter int FL_W  = 8,
    parameter int MF_W  = 5,
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_scram_en,
    input  logic [FL_W-1:0]   cfg_frame_len_m1,
    input  logic [MF_W-1:0]   cfg_mf_len_m1,
    input  logic              in_valid,
    input  logic [OCT_W-1:0]  in_data,
    input  logic              in_is_k,
    input  logic              in_mf_start,
    input  logic              err_clr,
    output logic              out_valid,
    output logic [OCT_W-1:0]  out_data,
    output logic              out_is_k,
    output logic              realign_req,
    output logic [ERR_W-1:0]  err_count
);
    octet_t            oct_in, oct_fix, out_q;
    logic              frame_end, mframe_end, misplaced;
    logic              valid_q, realign_q;
    logic [OCT_W-1:0]  prev_last_q;

    assign oct_in = '{data: in_data, is_k: in_is_k};

    lam_pos_ctr #(.FL_W(FL_W), .MF_W(MF_W)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .adv        (in_valid),
        .mf_start   (in_mf_start),
        .cfg_fl_m1  (cfg_frame_len_m1),
        .cfg_mf_m1  (cfg_mf_len_m1),
        .frame_end  (frame_end),
        .mframe_end (mframe_end)
    );

    lam_restore u_fix (
        .oct_in     (oct_in),
        .frame_end  (frame_end),
        .mframe_end (mframe_end),
        .scram_en   (cfg_scram_en),
        .prev_last  (prev_last_q),
        .oct_out    (oct_fix),
        .misplaced  (misplaced)
    );

    lam_err_ctr #(.W(ERR_W)) u_err (
        .clk   (clk),
        .rst   (rst),
        .clr   (err_clr),
        .inc   (in_valid && misplaced),
        .count (err_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q     <= 1'b0;
            realign_q   <= 1'b0;
            out_q       <= '0;
            prev_last_q <= '0;
        end else begin
            valid_q   <= in_valid;
            realign_q <= in_valid && misplaced;
            if (in_valid) begin
                out_q <= oct_fix;
                if (frame_end)
                    prev_last_q <= oct_fix.data;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_data    = out_q.data;
    assign out_is_k    = out_q.is_k;
    assign realign_req = realign_q;

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R5
    realign_src_chk: assert property (@(posedge clk) disable iff (rst)
        realign_req |-> ($past(in_valid) && $past(in_is_k) && out_valid && out_is_k));

    // R5
    misplaced_out_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_k && (out_data == FRAME_CHR || out_data == MFRAME_CHR))
            |-> realign_req);

    // R7
    err_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (realign_req && !$past(err_clr) && $past(err_count) != '1)
            |-> (err_count == $past(err_count) + 1'b1));

endmodule

// File: tb/lane_align_mon_bench.sv
`timescale 1ns/1ps
module lane_align_mon_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_scram_en = 1'b0;
    logic [7:0] cfg_frame_len_m1 = 8'd3;
    logic [4:0] cfg_mf_len_m1 = 5'd2;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_is_k = 1'b0;
    logic       in_mf_start = 1'b0;
    logic       err_clr = 1'b0;
    logic       out_valid, out_is_k, realign_req;
    logic [7:0] out_data, err_count;

    always #2.5 clk = ~clk;

    lane_align_mon u_lane_align_mon (
        .clk(clk), .rst(rst), .cfg_scram_en(cfg_scram_en),
        .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_mf_len_m1(cfg_mf_len_m1),
        .in_valid(in_valid), .in_data(in_data), .in_is_k(in_is_k),
        .in_mf_start(in_mf_start), .err_clr(err_clr),
        .out_valid(out_valid), .out_data(out_data), .out_is_k(out_is_k),
        .realign_req(realign_req), .err_count(err_count)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Behavioural reference model state
    int         m_oct = 0, m_frm = 0, m_err = 0;
    logic [7:0] m_prev = 8'h00;
    logic       exp_valid = 1'b0, exp_k = 1'b0, exp_rq = 1'b0;
    logic [7:0] exp_data = 8'h00;
    int         exp_err = 0;
    string      tag_v = "R9", tag_d = "R9", tag_k = "R9", tag_r = "R9", tag_e = "R9";

    always @(posedge clk) begin
        int  po, pf;
        bit  eof, eomf, is_f, is_a, ok, bad;
        bad = 1'b0;
        if (rst) begin
            m_oct = 0; m_frm = 0; m_err = 0; m_prev = 8'h00;
            exp_valid = 1'b0; exp_data = 8'h00; exp_k = 1'b0; exp_rq = 1'b0;
            tag_v = "R9"; tag_d = "R9"; tag_k = "R9"; tag_r = "R9"; tag_e = "R9";
        end else begin
            exp_valid = in_valid;
            exp_rq    = 1'b0;
            tag_v = "R8"; tag_r = "R6"; tag_e = "R7";
            if (in_valid) begin
                po   = in_mf_start ? 0 : m_oct;
                pf   = in_mf_start ? 0 : m_frm;
                eof  = (po == int'(cfg_frame_len_m1));
                eomf = eof && (pf == int'(cfg_mf_len_m1));
                is_f = in_is_k && in_data == 8'hFC;
                is_a = in_is_k && in_data == 8'h7C;
                ok   = (is_f && eof) || (is_a && eomf);
                bad  = (is_f || is_a) && !ok;
                exp_data = ok ? (cfg_scram_en ? in_data : m_prev) : in_data;
                exp_k    = ok ? 1'b0 : in_is_k;
                exp_rq   = bad;
                tag_d = ok ? (cfg_scram_en ? "R3" : "R4") : (bad ? "R1" : "R8");
                tag_k = ok ? "R2" : (bad ? "R5" : "R8");
                if (is_f || is_a) tag_r = "R5";
                if (eof) m_prev = exp_data;
                if (eof) begin
                    m_oct = 0;
                    m_frm = eomf ? 0 : pf + 1;
                end else begin
                    m_oct = po + 1;
                    m_frm = pf;
                end
            end
            if (err_clr) m_err = 0;
            else if (bad && m_err < 255) m_err = m_err + 1;
            exp_err = m_err;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(out_valid == exp_valid, tag_v, "out_valid", int'(out_valid), int'(exp_valid));
            chk(realign_req == exp_rq, tag_r, "realign_req", int'(realign_req), int'(exp_rq));
            chk(int'(err_count) == exp_err, tag_e, "err_count", int'(err_count), exp_err);
            if (exp_valid || tag_d == "R9") begin
                chk(out_data == exp_data, tag_d, "out_data", int'(out_data), int'(exp_data));
                chk(out_is_k == exp_k, tag_k, "out_is_k", int'(out_is_k), int'(exp_k));
            end
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic drv(input logic [7:0] d, input logic k,
                       input logic m = 1'b0, input logic c = 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_is_k = k; in_mf_start = m; err_clr = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_mf_start = 1'b0; err_clr = 1'b0; in_is_k = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        // R9: reset state observed by the per-cycle compare
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R1 R4 R6: unscrambled, 4-octet frames, 3 frames per multiframe
        cfg_scram_en = 1'b0; cfg_frame_len_m1 = 8'd3; cfg_mf_len_m1 = 5'd2;
        drv(8'h11, 0, 1); drv(8'h22, 0); drv(8'h33, 0); drv(8'h44, 0);
        drv(8'h55, 0); drv(8'h66, 0); idle(2); drv(8'h77, 0); drv(8'hFC, 1);
        drv(8'h88, 0); drv(8'h99, 0); drv(8'hAA, 0); drv(8'h7C, 1);
        // R4: chained repeated frames restore from restored octets
        for (int f = 0; f < 6; f++) begin
            drv(8'h10 + 8'(f), 0); drv(8'h20, 0); drv(8'h30, 0);
            drv((f % 3 == 2) ? 8'h7C : 8'hFC, 1);
        end

        // R5: misplaced characters
        drv(8'h01, 0); drv(8'hFC, 1); drv(8'h03, 0); drv(8'h7C, 1);
        drv(8'h05, 0); drv(8'h06, 0); drv(8'h07, 0); drv(8'h08, 0);
        drv(8'hFC, 1); drv(8'h7C, 1); drv(8'h0B, 0); drv(8'h7C, 1);

        // R8: other control characters and plain 0xFC data pass through
        drv(8'hBC, 1, 1); drv(8'hFC, 0); drv(8'h7C, 0); drv(8'hBC, 1);

        // R3: scrambled mode
        cfg_scram_en = 1'b1;
        drv(8'h5A, 0, 1); drv(8'hA5, 0); drv(8'h3C, 0); drv(8'hFC, 1);
        drv(8'h5A, 0); drv(8'hA5, 0); drv(8'h3C, 0); drv(8'hFC, 1);
        drv(8'h12, 0); drv(8'h34, 0); drv(8'h56, 0); drv(8'h7C, 1);

        // R6: restart mid-frame, then boundaries follow the new start
        drv(8'h01, 0); drv(8'h02, 0); drv(8'h03, 0, 1); drv(8'h04, 0);
        drv(8'h05, 0); drv(8'hFC, 1);
        // alignment character on the strobe octet itself (position 0)
        drv(8'h7C, 1, 1);

        // R1: single-octet frames and multiframes, unscrambled
        cfg_scram_en = 1'b0; cfg_frame_len_m1 = 8'd0; cfg_mf_len_m1 = 5'd0;
        drv(8'h42, 0, 1); drv(8'hFC, 1); drv(8'h7C, 1); drv(8'h99, 0); drv(8'h7C, 1);

        // R7: saturation, then clear colliding with a misplaced character
        cfg_frame_len_m1 = 8'd3; cfg_mf_len_m1 = 5'd2;
        drv(8'h00, 0, 1);
        for (int i = 0; i < 360; i++) drv(8'hFC, 1);
        drv(8'hFC, 1, 1, 1);
        drv(8'hFC, 1);
        drv(8'hFC, 1, 0, 1);
        idle(2);

        // Mixed traffic with occasional restarts, mode switches and clears
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic m;
            r = int'($urandom % 16);
            m = ($urandom % 64) == 0;
            if (m && ($urandom % 4) == 0) begin
                cfg_scram_en = ~cfg_scram_en;
                cfg_frame_len_m1 = 8'($urandom % 6);
                cfg_mf_len_m1 = 5'($urandom % 4);
            end
            if (r == 0)      drv(8'hFC, 1, m, ($urandom % 100) == 0);
            else if (r == 1) drv(8'h7C, 1, m);
            else if (r == 2) drv(8'hBC, 1, m);
            else if (r == 3 && !m) idle(1);
            else             drv(8'($urandom), 0, m, ($urandom % 200) == 0);
        end
        idle(3);
        finish_up();
    end

endmodule